// File: doc/BRIEF.md
# Six-Stage Pipeline Interlock and Bypass Controller

This block decides, for an in-order pipeline with six stages, whether the instruction waiting in decode may move on and where each operand must come from. The stages are fetch, decode, address calculation (with its own adder), operand fetch, execute (the main ALU) and write-back. The controller keeps a small record of every instruction in flight: its destination register, whether it writes one, whether it is a load, and which sources it reads. It compares the decode-stage instruction against the older records. It then either raises `stall` or, when bypassing is enabled, steers the operand multiplexers with 2-bit select codes.

Decode presents one instruction with `dec_valid`. `stall` is the back-pressure signal for that stream. While `stall` is high and `dec_valid` is high, the decode instruction is not accepted: fetch and decode must hold it and present it again unchanged. The controller puts a bubble into the address stage, and the older stages keep advancing. The instruction is taken on the first rising edge at which `stall` is low. Two mode pins set the behaviour. `fwd_en` turns bypassing on. `split_rf` says the register file is written in the first half of a cycle and read in the second half, so a read that overlaps the producer's write-back sees the new value.

The base register of a memory operand is read in decode and used by the adder in the address stage. ALU operands are read in operand fetch and used in execute. A load's data exists only in the write-back result latch. Its execute-stage latch holds no usable value.

Top module: `hzc_ctrl`

## Requirements
- R1: An accepted instruction enters the address stage on the next edge, and each record advances one stage per cycle whatever `stall` does. A cycle with `stall` high puts a bubble into the address stage.
- R2: With `fwd_en`=0, an ALU source matching a producer in the address stage stalls. One matching a producer in operand fetch stalls when `split_rf`=0.
- R3: With `fwd_en`=0, a base register matching a producer in the address, operand-fetch or execute stage stalls. One matching a producer in write-back stalls when `split_rf`=0.
- R4: With `split_rf`=1 and `fwd_en`=0, a read that overlaps the producer's write-back causes no stall.
- R5: With `fwd_en`=1, the ALU source selects (`ei_a_sel`, `ei_b_sel`) for the instruction in execute are 01 when the match is in write-back and is not a load, 10 when the match is the instruction that left write-back in the previous cycle, and 00 otherwise. Code 11 never appears.
- R6: With `fwd_en`=1, a base register matching a producer in the address or operand-fetch stage stalls. The base select `co_base_sel` for the instruction in the address stage follows the same 01/10/00 codes as R5.
- R7: With `fwd_en`=1, a base register matching a load in execute stalls. An ALU source matching a load in the address stage stalls for one cycle.
- R8: When both bypass sources match, the younger producer (code 01) wins.
- R9: Register 0 never creates a dependency or a bypass. Bubbles and instructions that do not write a register never match.
- R10: `stall` is low whenever `dec_valid` is low. With `fwd_en`=0 all selects are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, empties all records |
| fwd_en | input | 1 | 1 = bypass operation, 0 = stall-only |
| split_rf | input | 1 | 1 = write then read in the same cycle |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_wr | input | 1 | Instruction writes `dec_rd` |
| dec_rd | input | 5 | Destination register |
| dec_load | input | 1 | Instruction is a load |
| dec_use_base | input | 1 | Base register is needed by the address adder |
| dec_base | input | 5 | Base register number |
| dec_use_a | input | 1 | ALU source A is used |
| dec_src_a | input | 5 | ALU source A register |
| dec_use_b | input | 1 | ALU source B is used |
| dec_src_b | input | 5 | ALU source B register |
| stall | output | 1 | Hold fetch and decode, put a bubble into the address stage |
| co_base_sel | output | 2 | Base mux select for the address-stage instruction |
| ei_a_sel | output | 2 | Operand A mux select for the execute-stage instruction |
| ei_b_sel | output | 2 | Operand B mux select for the execute-stage instruction |

## Verification
Each pattern is a producer writing R5, then a gap of one to five cycles, then a consumer reading R5 as a base, as source A or as source B. This is run under every combination of mode and producer kind. The number of stall cycles shows which stage comparisons are live in each mode, and the select code sampled when the consumer reaches its use stage shows which latch the value is taken from. Further cases cover two back-to-back writers of the same register (priority), register 0, bubbles that carry a stale register number, and the state right after reset.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int unsigned HZ_REG_W = 5;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_EX = 2'b01,
    SEL_WB = 2'b10
  } byp_sel_e;

  typedef struct packed {
    logic                valid;
    logic                wr;
    logic                load;
    logic [HZ_REG_W-1:0] rd;
    logic                use_base;
    logic [HZ_REG_W-1:0] base;
    logic                use_a;
    logic [HZ_REG_W-1:0] src_a;
    logic                use_b;
    logic [HZ_REG_W-1:0] src_b;
  } stage_t;

  // true when producer p writes register r that a consumer actually reads
  function automatic logic hz_hit(stage_t p, logic use_r, logic [HZ_REG_W-1:0] r);
    return use_r && (r != '0) && p.valid && p.wr && (p.rd == r);
  endfunction
endpackage

// File: rtl/hzc_track.sv
module hzc_track
  import hzc_pkg::*;
#(
  parameter int unsigned DEPTH = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stall,
  input  stage_t                 din,
  output stage_t [DEPTH-1:0]     q
);
  stage_t [DEPTH-1:0] r;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     r[0] <= '0;
        else if (stall) r[0] <= '0;
        else            r[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) r[i] <= '0;
        else        r[i] <= r[i-1];
      end
    end
  end

  assign q = r;
endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
  import hzc_pkg::*;
(
  input  logic   fwd_en,
  input  logic   split_rf,
  input  stage_t dec,
  input  stage_t co,
  input  stage_t fo,
  input  stage_t ei,
  input  stage_t wo,
  output logic   stall
);
  logic base_haz, alu_haz;
  logic a_co, a_fo, b_co, b_fo;

  always_comb begin
    a_co = hz_hit(co, dec.use_a, dec.src_a);
    b_co = hz_hit(co, dec.use_b, dec.src_b);
    a_fo = hz_hit(fo, dec.use_a, dec.src_a);
    b_fo = hz_hit(fo, dec.use_b, dec.src_b);
    if (fwd_en) begin
      base_haz = hz_hit(co, dec.use_base, dec.base)
               | hz_hit(fo, dec.use_base, dec.base)
               | (hz_hit(ei, dec.use_base, dec.base) && ei.load);
      alu_haz  = (a_co | b_co) && co.load;
    end else begin
      base_haz = hz_hit(co, dec.use_base, dec.base)
               | hz_hit(fo, dec.use_base, dec.base)
               | hz_hit(ei, dec.use_base, dec.base)
               | (hz_hit(wo, dec.use_base, dec.base) && !split_rf);
      alu_haz  = a_co | b_co | ((a_fo | b_fo) && !split_rf);
    end
    stall = dec.valid && (base_haz || alu_haz);
  end
endmodule

// File: rtl/hzc_bypass.sv
module hzc_bypass
  import hzc_pkg::*;
(
  input  logic                fwd_en,
  input  logic                use_r,
  input  logic [HZ_REG_W-1:0] r,
  input  stage_t              near,
  input  stage_t              far,
  output logic [1:0]          sel
);
  always_comb begin
    if (!fwd_en)                                  sel = SEL_RF;
    else if (hz_hit(near, use_r, r) && !near.load) sel = SEL_EX;
    else if (hz_hit(far, use_r, r))               sel = SEL_WB;
    else                                          sel = SEL_RF;
  end
endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned REG_W = HZ_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_en,
  input  logic             split_rf,
  input  logic             dec_valid,
  input  logic             dec_wr,
  input  logic [REG_W-1:0] dec_rd,
  input  logic             dec_load,
  input  logic             dec_use_base,
  input  logic [REG_W-1:0] dec_base,
  input  logic             dec_use_a,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic             dec_use_b,
  input  logic [REG_W-1:0] dec_src_b,
  output logic             stall,
  output logic [1:0]       co_base_sel,
  output logic [1:0]       ei_a_sel,
  output logic [1:0]       ei_b_sel
);
  localparam int unsigned N_TRK = 5;  // CO, FO, EI, WO, retired
  localparam int unsigned N_OPS = 3;
  localparam int unsigned S_CO = 0, S_FO = 1, S_EI = 2, S_WO = 3, S_RT = 4;

  stage_t                 dec_rec;
  stage_t [N_TRK-1:0]     trk_q;
  logic   [N_OPS-1:0]     op_use;
  logic   [HZ_REG_W-1:0]  op_reg [N_OPS];
  logic   [1:0]           op_sel [N_OPS];

  always_comb begin
    dec_rec          = '0;
    dec_rec.valid    = dec_valid;
    dec_rec.wr       = dec_wr;
    dec_rec.load     = dec_load;
    dec_rec.rd       = dec_rd;
    dec_rec.use_base = dec_use_base;
    dec_rec.base     = dec_base;
    dec_rec.use_a    = dec_use_a;
    dec_rec.src_a    = dec_src_a;
    dec_rec.use_b    = dec_use_b;
    dec_rec.src_b    = dec_src_b;
  end

  hzc_track #(.DEPTH(N_TRK)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .din   (dec_rec),
    .q     (trk_q)
  );

  hzc_interlock u_lock (
    .fwd_en   (fwd_en),
    .split_rf (split_rf),
    .dec      (dec_rec),
    .co       (trk_q[S_CO]),
    .fo       (trk_q[S_FO]),
    .ei       (trk_q[S_EI]),
    .wo       (trk_q[S_WO]),
    .stall    (stall)
  );

  // base is consumed in CO, ALU operands in EI; both draw from WO and retired
  assign op_use[0] = trk_q[S_CO].use_base;
  assign op_reg[0] = trk_q[S_CO].base;
  assign op_use[1] = trk_q[S_EI].use_a;
  assign op_reg[1] = trk_q[S_EI].src_a;
  assign op_use[2] = trk_q[S_EI].use_b;
  assign op_reg[2] = trk_q[S_EI].src_b;

  for (genvar k = 0; k < N_OPS; k++) begin : g_byp
    hzc_bypass u_byp (
      .fwd_en (fwd_en),
      .use_r  (op_use[k]),
      .r      (op_reg[k]),
      .near   (trk_q[S_WO]),
      .far    (trk_q[S_RT]),
      .sel    (op_sel[k])
    );
  end

  assign co_base_sel = op_sel[0];
  assign ei_a_sel    = op_sel[1];
  assign ei_b_sel    = op_sel[2];
endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fwd_en,
  input logic       dec_valid,
  input logic       dec_use_base,
  input logic [4:0] dec_base,
  input logic       dec_use_a,
  input logic [4:0] dec_src_a,
  input logic       dec_use_b,
  input logic [4:0] dec_src_b,
  input logic       stall,
  input logic [1:0] co_base_sel,
  input logic [1:0] ei_a_sel,
  input logic [1:0] ei_b_sel,
  input logic       co_valid
);
  a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);

  a_r9_zero_regs_free: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (!dec_use_base || dec_base == '0) && (!dec_use_a || dec_src_a == '0)
     && (!dec_use_b || dec_src_b == '0)) |-> !stall);

  a_r10_rf_only_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> (co_base_sel == 2'b00 && ei_a_sel == 2'b00 && ei_b_sel == 2'b00));

  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (co_base_sel != 2'b11) && (ei_a_sel != 2'b11) && (ei_b_sel != 2'b11));

  a_r1_bubble_in_co: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !co_valid);
endmodule

bind hzc_ctrl hzc_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fwd_en       (fwd_en),
  .dec_valid    (dec_valid),
  .dec_use_base (dec_use_base),
  .dec_base     (dec_base),
  .dec_use_a    (dec_use_a),
  .dec_src_a    (dec_src_a),
  .dec_use_b    (dec_use_b),
  .dec_src_b    (dec_src_b),
  .stall        (stall),
  .co_base_sel  (co_base_sel),
  .ei_a_sel     (ei_a_sel),
  .ei_b_sel     (ei_b_sel),
  .co_valid     (trk_q[0].valid)
);

// File: tb/hzc_ctrl_bench.sv
module hzc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 19;

  // {fwd, split, prod_load, distance[2:0], kind[1:0] (0 base,1 A,2 B), stalls[2:0], sel[1:0]}
  localparam logic [12:0] VEC [N_VEC] = '{
    {1'b0,1'b0,1'b0,3'd1,2'd1,3'd2,2'd0},  // R2
    {1'b0,1'b0,1'b0,3'd2,2'd1,3'd1,2'd0},  // R2
    {1'b0,1'b1,1'b0,3'd2,2'd1,3'd0,2'd0},  // R4
    {1'b0,1'b1,1'b0,3'd1,2'd2,3'd1,2'd0},  // R2 R4
    {1'b0,1'b0,1'b0,3'd1,2'd0,3'd4,2'd0},  // R3
    {1'b0,1'b1,1'b0,3'd1,2'd0,3'd3,2'd0},  // R3 R4
    {1'b0,1'b0,1'b0,3'd4,2'd0,3'd1,2'd0},  // R3
    {1'b0,1'b1,1'b0,3'd4,2'd0,3'd0,2'd0},  // R4
    {1'b1,1'b0,1'b0,3'd1,2'd1,3'd0,2'd1},  // R5
    {1'b1,1'b0,1'b0,3'd2,2'd2,3'd0,2'd2},  // R5
    {1'b1,1'b0,1'b0,3'd3,2'd1,3'd0,2'd0},  // R5
    {1'b1,1'b0,1'b1,3'd1,2'd1,3'd1,2'd2},  // R7
    {1'b1,1'b0,1'b1,3'd2,2'd2,3'd0,2'd2},  // R7
    {1'b1,1'b0,1'b0,3'd1,2'd0,3'd2,2'd1},  // R6
    {1'b1,1'b0,1'b0,3'd3,2'd0,3'd0,2'd1},  // R6
    {1'b1,1'b0,1'b1,3'd3,2'd0,3'd1,2'd2},  // R7
    {1'b1,1'b0,1'b0,3'd4,2'd0,3'd0,2'd2},  // R6
    {1'b1,1'b1,1'b0,3'd5,2'd0,3'd0,2'd0},  // R6
    {1'b1,1'b0,1'b1,3'd1,2'd0,3'd3,2'd2}   // R7
  };

  logic clk = 0, rst_n = 0;
  logic fwd_en = 0, split_rf = 0, dec_valid = 0, dec_wr = 0, dec_load = 0;
  logic dec_use_base = 0, dec_use_a = 0, dec_use_b = 0;
  logic [4:0] dec_rd = 0, dec_base = 0, dec_src_a = 0, dec_src_b = 0;
  logic stall;
  logic [1:0] co_base_sel, ei_a_sel, ei_b_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzc_ctrl u_hzc_ctrl (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .split_rf(split_rf),
    .dec_valid(dec_valid), .dec_wr(dec_wr), .dec_rd(dec_rd), .dec_load(dec_load),
    .dec_use_base(dec_use_base), .dec_base(dec_base),
    .dec_use_a(dec_use_a), .dec_src_a(dec_src_a),
    .dec_use_b(dec_use_b), .dec_src_b(dec_src_b),
    .stall(stall), .co_base_sel(co_base_sel), .ei_a_sel(ei_a_sel), .ei_b_sel(ei_b_sel)
  );

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic clear_dec();
    dec_valid = 0; dec_wr = 0; dec_load = 0; dec_rd = 0;
    dec_use_base = 0; dec_base = 0; dec_use_a = 0; dec_src_a = 0;
    dec_use_b = 0; dec_src_b = 0;
  endtask

  task automatic put_writer(logic v, logic [4:0] rd, logic ld);
    clear_dec();
    dec_valid = v; dec_wr = 1; dec_rd = rd; dec_load = ld;
  endtask

  task automatic put_reader(int kind, logic [4:0] r);
    clear_dec();
    dec_valid = 1;
    if (kind == 0) begin dec_use_base = 1; dec_base = r; end
    else if (kind == 1) begin dec_use_a = 1; dec_src_a = r; end
    else begin dec_use_b = 1; dec_src_b = r; end
  endtask

  task automatic drain();
    @(negedge clk); clear_dec();
    repeat (7) @(negedge clk);
  endtask

  // present consumer at current negedge; return stall count and use-stage select
  task automatic consume(int kind, logic [4:0] r, output int n_stall, output int sel);
    put_reader(kind, r);
    n_stall = 0;
    #1;
    while (stall && n_stall < 20) begin
      n_stall++;
      @(negedge clk); #1;
    end
    @(negedge clk);            // consumer now in CO
    clear_dec();
    if (kind == 0) sel = co_base_sel;
    else begin
      repeat (2) @(negedge clk);  // CO -> FO -> EI
      sel = (kind == 1) ? ei_a_sel : ei_b_sel;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ns, sl;
    repeat (3) @(negedge clk);
    // R10: reset state, a dependent reader would stall if records survived reset
    put_reader(0, 5'd5);
    #1;
    check("R10 stall during reset", stall, 0);
    check("R10 base sel during reset", co_base_sel, 0);
    @(negedge clk); rst_n = 1; clear_dec();
    #1;
    check("R10 stall idle after reset", stall, 0);
    check("R10 ei_a_sel after reset", ei_a_sel, 0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [12:0] v;
      string tag;
      v = VEC[i];
      fwd_en = v[12]; split_rf = v[11];
      drain();
      put_writer(1'b1, 5'd5, v[10]);
      @(negedge clk); clear_dec();
      for (int g = 1; g < int'(v[9:7]); g++) @(negedge clk);
      consume(int'(v[6:5]), 5'd5, ns, sl);
      tag = v[12] ? (v[10] ? "R7 load" : (v[6:5] == 0 ? "R6 base" : "R5 alu"))
                  : (v[11] ? "R4 split" : (v[6:5] == 0 ? "R3 base" : "R2 alu"));
      check($sformatf("%s vec%0d stalls (R1)", tag, i), ns, int'(v[4:2]));
      check($sformatf("%s vec%0d select", tag, i), sl, int'(v[1:0]));
    end

    // R8: two writers of R5 back to back, reader right behind -> younger wins
    fwd_en = 1; split_rf = 0;
    drain();
    put_writer(1'b1, 5'd5, 1'b0);
    @(negedge clk); put_writer(1'b1, 5'd5, 1'b0);
    @(negedge clk);
    consume(1, 5'd5, ns, sl);
    check("R8 priority stalls", ns, 0);
    check("R8 priority select", sl, 1);

    // R9: register 0 never depends (stall-only, base, distance 1)
    fwd_en = 0;
    drain();
    put_writer(1'b1, 5'd0, 1'b0);
    @(negedge clk);
    consume(0, 5'd0, ns, sl);
    check("R9 reg0 stalls", ns, 0);

    // R9: bubble carrying stale rd never matches
    drain();
    put_writer(1'b0, 5'd7, 1'b0);
    @(negedge clk);
    consume(1, 5'd7, ns, sl);
    check("R9 bubble stalls", ns, 0);

    // R9: reg0 never forwarded
    fwd_en = 1;
    drain();
    put_writer(1'b1, 5'd0, 1'b0);
    @(negedge clk);
    consume(1, 5'd0, ns, sl);
    check("R9 reg0 select", sl, 0);

    // R10: writer in flight but no valid reader -> no stall
    fwd_en = 0;
    drain();
    put_writer(1'b1, 5'd9, 1'b0);
    @(negedge clk); put_reader(0, 5'd9); dec_valid = 0;
    #1;
    check("R10 invalid reader no stall", stall, 0);

    drain();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule